// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table that sits in memory. A lookup request carries the virtual address and a table base value. The walker fetches the first-level descriptor through a single-word memory read port. It decodes the descriptor's type. When the descriptor points to a second-level table, it fetches one more word from that table. It then presents one response: the physical address, a page-size code, the domain number, eight access-permission bits and a fault flag with the level at which the fault arose.

Mapping sizes of 16 MB, 1 MB, 64 KB, 4 KB and 1 KB are all resolved from these two descriptor levels. A first-level entry can point to one of two kinds of second-level table:
- a 1 KB table holding 256 entries, indexed by VA[19:12];
- a 4 KB table holding 1024 entries, indexed by VA[19:10].

Only one walk is in flight at a time. The memory must answer a read no earlier than the cycle after the read pulse.

Top module: `tw_walker`

## Requirements
- R1: `req_ready_o` is high only while idle. A request is taken at a clock edge where `req_valid_i` and `req_ready_o` are both high. From the next cycle, `busy_o` is high and `req_ready_o` is low, and both stay so until the edge where `resp_valid_o` and `resp_ready_i` are both high.
- R2: The first read of every walk uses the address {base[31:14], VA[31:20], 2'b00}.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk with `resp_fault_o`=1 and `resp_fault_lvl_o`=0. Exactly one read is issued for that walk.
- R4: A first-level descriptor with bits [1:0] = 10 and bit 18 clear gives PA = {d[31:20], VA[19:0]} and size code 3. Permissions are bits [11:10] repeated four times as {ap,ap,ap,ap}. Domain is d[8:5].
- R5: A first-level descriptor with bits [1:0] = 10 and bit 18 set gives PA = {d[31:24], VA[23:0]} and size code 4. Permissions and domain follow the rule in R4.
- R6: First-level type 01 makes the second read at {d[31:10], VA[19:12], 2'b00}. First-level type 11 makes it at {d[31:12], VA[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 01 gives PA = {d2[31:16], VA[15:0]}, size code 2 and permissions d2[11:4].
- R8: A second-level descriptor with bits [1:0] = 10 gives PA = {d2[31:12], VA[11:0]}, size code 1 and permissions d2[11:4].
- R9: A second-level descriptor with bits [1:0] = 11 gives PA = {d2[31:10], VA[9:0]}, size code 0 and permissions d2[5:4] repeated four times.
- R10: A second-level descriptor with bits [1:0] = 00 ends the walk with `resp_fault_o`=1 and `resp_fault_lvl_o`=1, after exactly two reads. For any successful walk that reaches the second level, the domain is bits [8:5] of the first-level descriptor.
- R11: A faulting response reports PA, size code, domain and permissions all as zero.
- R12: Every read is a one-cycle pulse on `mem_req_o`. No new read is issued while a response is pending. The response outputs hold steady while `resp_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Walker idle, can take a request |
| req_va_i | input | 32 | Virtual address to translate |
| req_base_i | input | 32 | Table base value; bits [31:14] are used |
| busy_o | output | 1 | Walk in progress or response pending |
| mem_req_o | output | 1 | One-cycle word read pulse |
| mem_addr_o | output | 32 | Word read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| resp_valid_o | output | 1 | Response valid |
| resp_ready_i | input | 1 | Response accepted |
| resp_fault_o | output | 1 | Translation fault |
| resp_fault_lvl_o | output | 1 | Fault level: 0 first, 1 second |
| resp_pa_o | output | 32 | Physical address |
| resp_size_o | output | 3 | Size code: 0=1K, 1=4K, 2=64K, 3=1M, 4=16M |
| resp_dom_o | output | 4 | Domain number |
| resp_ap_o | output | 8 | Permissions, one 2-bit field per quarter page |

## Verification
The first read pulse is due in the cycle after the request is taken. The response becomes valid in the cycle after the last read data arrives, so a walk takes two or three cycles plus the memory latency. The bench's memory model answers one to three cycles after each pulse and records every read address. The bench samples on falling edges: busy and ready one cycle after acceptance, then it waits for `resp_valid_o` before comparing the fields. While the response is held back it checks that the fields and the read count stay put. After the handshake it checks that the walker is idle again.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int AW          = 32;
  localparam int AP_W        = 8;
  localparam int DOM_W       = 4;
  localparam int DOM_LSB     = 5;
  localparam int L1_BASE_SH  = 14;
  localparam int SEC_SH      = 20;
  localparam int SUP_SH      = 24;
  localparam int LRG_SH      = 16;
  localparam int SML_SH      = 12;
  localparam int TNY_SH      = 10;
  localparam int CRS_BASE_SH = 10;
  localparam int FIN_BASE_SH = 12;
  localparam int SUP_BIT     = 18;
  localparam int SEC_AP_LSB  = 10;
  localparam int PG_AP_LSB   = 4;

  typedef enum logic [2:0] {
    SZ_1K  = 3'd0,
    SZ_4K  = 3'd1,
    SZ_64K = 3'd2,
    SZ_1M  = 3'd3,
    SZ_16M = 3'd4
  } pg_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_L1_FETCH,
    ST_L2_FETCH,
    ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic              fault;
    logic              lvl;
    logic [AW-1:0]     pa;
    pg_size_e          size;
    logic [DOM_W-1:0]  dom;
    logic [AP_W-1:0]   ap;
  } walk_res_t;

  function automatic logic [AW-1:0] low_mask(input int sh);
    return (AW'(1) << sh) - AW'(1);
  endfunction

  // frame bits from the descriptor, offset bits from the VA
  function automatic logic [AW-1:0] join_frame(input logic [AW-1:0] d,
                                               input logic [AW-1:0] v,
                                               input int sh);
    return (d & ~low_mask(sh)) | (v & low_mask(sh));
  endfunction

  // table base from the descriptor, word index from VA[hi_sh-1:idx_sh]
  function automatic logic [AW-1:0] table_addr(input logic [AW-1:0] d,
                                               input logic [AW-1:0] v,
                                               input int base_sh,
                                               input int hi_sh,
                                               input int idx_sh);
    logic [AW-1:0] idx;
    idx = (v & low_mask(hi_sh)) >> idx_sh;
    return (d & ~low_mask(base_sh)) | (idx << 2);
  endfunction
endpackage

// File: rtl/tw_l1_dec.sv
module tw_l1_dec
  import tw_pkg::*;
(
  input  logic [AW-1:0] desc_i,
  input  logic [AW-1:0] va_i,
  output logic          is_table_o,
  output logic [AW-1:0] l2_addr_o,
  output walk_res_t     res_o
);
  logic [1:0] ap_f;
  assign ap_f = desc_i[SEC_AP_LSB +: 2];

  always_comb begin
    res_o      = '0;
    is_table_o = 1'b0;
    l2_addr_o  = '0;
    unique case (desc_i[1:0])
      2'b00: begin
        res_o.fault = 1'b1;
        res_o.lvl   = 1'b0;
      end
      2'b10: begin
        res_o.dom = desc_i[DOM_LSB +: DOM_W];
        res_o.ap  = {4{ap_f}};
        if (desc_i[SUP_BIT]) begin
          res_o.pa   = join_frame(desc_i, va_i, SUP_SH);
          res_o.size = SZ_16M;
        end else begin
          res_o.pa   = join_frame(desc_i, va_i, SEC_SH);
          res_o.size = SZ_1M;
        end
      end
      2'b01: begin
        is_table_o = 1'b1;
        res_o.dom  = desc_i[DOM_LSB +: DOM_W];
        l2_addr_o  = table_addr(desc_i, va_i, CRS_BASE_SH, SEC_SH, SML_SH);
      end
      default: begin
        is_table_o = 1'b1;
        res_o.dom  = desc_i[DOM_LSB +: DOM_W];
        l2_addr_o  = table_addr(desc_i, va_i, FIN_BASE_SH, SEC_SH, TNY_SH);
      end
    endcase
  end
endmodule

// File: rtl/tw_l2_dec.sv
module tw_l2_dec
  import tw_pkg::*;
(
  input  logic [AW-1:0]    desc_i,
  input  logic [AW-1:0]    va_i,
  input  logic [DOM_W-1:0] dom_i,
  output walk_res_t        res_o
);
  always_comb begin
    res_o = '0;
    unique case (desc_i[1:0])
      2'b00: begin
        res_o.fault = 1'b1;
        res_o.lvl   = 1'b1;
      end
      2'b01: begin
        res_o.pa   = join_frame(desc_i, va_i, LRG_SH);
        res_o.size = SZ_64K;
        res_o.ap   = desc_i[PG_AP_LSB +: AP_W];
        res_o.dom  = dom_i;
      end
      2'b10: begin
        res_o.pa   = join_frame(desc_i, va_i, SML_SH);
        res_o.size = SZ_4K;
        res_o.ap   = desc_i[PG_AP_LSB +: AP_W];
        res_o.dom  = dom_i;
      end
      default: begin
        res_o.pa   = join_frame(desc_i, va_i, TNY_SH);
        res_o.size = SZ_1K;
        res_o.ap   = {4{desc_i[PG_AP_LSB +: 2]}};
        res_o.dom  = dom_i;
      end
    endcase
  end
endmodule

// File: rtl/tw_walker.sv
module tw_walker
  import tw_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_va_i,
  input  logic [31:0]   req_base_i,
  output logic          busy_o,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          resp_valid_o,
  input  logic          resp_ready_i,
  output logic          resp_fault_o,
  output logic          resp_fault_lvl_o,
  output logic [31:0]   resp_pa_o,
  output logic [2:0]    resp_size_o,
  output logic [3:0]    resp_dom_o,
  output logic [7:0]    resp_ap_o
);
  walk_st_e         state_q;
  logic             issued_q;
  logic [AW-1:0]    va_q;
  logic [AW-1:0]    addr_q;
  logic [DOM_W-1:0] dom_q;
  walk_res_t        res_q;

  logic             l1_table;
  logic [AW-1:0]    l1_l2_addr;
  walk_res_t        l1_res;
  walk_res_t        l2_res;
  logic [AW-1:0]    l1_addr;
  logic             fetch_st;
  logic             rd_done;

  assign l1_addr = table_addr(req_base_i, req_va_i, L1_BASE_SH, AW, SEC_SH);

  tw_l1_dec u_l1_dec (
    .desc_i     (mem_rdata_i),
    .va_i       (va_q),
    .is_table_o (l1_table),
    .l2_addr_o  (l1_l2_addr),
    .res_o      (l1_res)
  );

  tw_l2_dec u_l2_dec (
    .desc_i (mem_rdata_i),
    .va_i   (va_q),
    .dom_i  (dom_q),
    .res_o  (l2_res)
  );

  assign fetch_st = (state_q == ST_L1_FETCH) || (state_q == ST_L2_FETCH);
  assign rd_done  = fetch_st && issued_q && mem_rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      va_q     <= '0;
      addr_q   <= '0;
      dom_q    <= '0;
      res_q    <= '0;
    end else begin
      if (mem_req_o) issued_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q     <= req_va_i;
            addr_q   <= l1_addr;
            issued_q <= 1'b0;
            state_q  <= ST_L1_FETCH;
          end
        end
        ST_L1_FETCH: begin
          if (rd_done) begin
            if (l1_table) begin
              addr_q   <= l1_l2_addr;
              dom_q    <= l1_res.dom;
              issued_q <= 1'b0;
              state_q  <= ST_L2_FETCH;
            end else begin
              res_q   <= l1_res;
              state_q <= ST_DONE;
            end
          end
        end
        ST_L2_FETCH: begin
          if (rd_done) begin
            res_q   <= l2_res;
            state_q <= ST_DONE;
          end
        end
        default: begin
          if (resp_ready_i) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign busy_o           = (state_q != ST_IDLE);
  assign mem_req_o        = fetch_st && !issued_q;
  assign mem_addr_o       = addr_q;
  assign resp_valid_o     = (state_q == ST_DONE);
  assign resp_fault_o     = res_q.fault;
  assign resp_fault_lvl_o = res_q.lvl;
  assign resp_pa_o        = res_q.pa;
  assign resp_size_o      = res_q.size;
  assign resp_dom_o       = res_q.dom;
  assign resp_ap_o        = res_q.ap;

  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(resp_valid_o && resp_ready_i) |=> busy_o && !req_ready_o); // R1
  AST_FIRST_READ_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_req_o &&
      mem_addr_o == {$past(req_base_i[31:14]), $past(req_va_i[31:20]), 2'b00}); // R2
  AST_NO_READ_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !mem_req_o); // R12
  AST_READ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R12
  AST_RESP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && !resp_ready_i |=> resp_valid_o && $stable(resp_pa_o) &&
      $stable(resp_ap_o) && $stable(resp_fault_o) && $stable(resp_size_o)); // R12
  AST_FAULT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_fault_o |-> resp_pa_o == '0 && resp_ap_o == '0 &&
      resp_dom_o == '0 && resp_size_o == '0); // R11
endmodule

// File: tb/tw_walker_test.sv
module tw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [31:0] req_base = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        resp_ready = 1'b0;
  logic        req_ready, busy, mem_req, resp_valid, resp_fault, resp_lvl;
  logic [31:0] mem_addr, resp_pa;
  logic [2:0]  resp_size;
  logic [3:0]  resp_dom;
  logic [7:0]  resp_ap;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr [4];
  logic [31:0] bmem [logic [31:0]];

  always #5 clk = ~clk;

  tw_walker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_base_i(req_base), .busy_o(busy),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .resp_valid_o(resp_valid), .resp_ready_i(resp_ready),
    .resp_fault_o(resp_fault), .resp_fault_lvl_o(resp_lvl),
    .resp_pa_o(resp_pa), .resp_size_o(resp_size),
    .resp_dom_o(resp_dom), .resp_ap_o(resp_ap)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model: answers 1..3 cycles after each read pulse
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [31:0] a;
        a = mem_addr;
        if (rd_cnt < 4) rd_addr[rd_cnt] = a;
        rd_cnt++;
        repeat (1 + int'($urandom_range(2))) @(negedge clk);
        mem_rdata  = rd(a);
        mem_rvalid = 1'b1;
      end
    end
  end

  // reference walk computed from the requirements
  task automatic ref_walk(input logic [31:0] va, input logic [31:0] base,
                          output logic f, output logic lvl, output logic [31:0] pa,
                          output logic [2:0] sz, output logic [3:0] dom,
                          output logic [7:0] ap, output int nrd,
                          output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] d1, d2;
    f = 0; lvl = 0; pa = 0; sz = 0; dom = 0; ap = 0; a1 = 0;
    a0 = {base[31:14], va[31:20], 2'b00};                 // R2
    d1 = rd(a0);
    nrd = 1;
    case (d1[1:0])
      2'b00: begin f = 1; lvl = 0; end                    // R3
      2'b10: begin
        dom = d1[8:5];
        ap = {4{d1[11:10]}};
        if (d1[18]) begin pa = {d1[31:24], va[23:0]}; sz = 3'd4; end   // R5
        else begin pa = {d1[31:20], va[19:0]}; sz = 3'd3; end          // R4
      end
      default: begin
        if (d1[1:0] == 2'b01) a1 = {d1[31:10], va[19:12], 2'b00};     // R6
        else a1 = {d1[31:12], va[19:10], 2'b00};
        nrd = 2;
        d2 = rd(a1);
        case (d2[1:0])
          2'b00: begin f = 1; lvl = 1; end                              // R10
          2'b01: begin pa = {d2[31:16], va[15:0]}; sz = 3'd2; ap = d2[11:4]; dom = d1[8:5]; end // R7
          2'b10: begin pa = {d2[31:12], va[11:0]}; sz = 3'd1; ap = d2[11:4]; dom = d1[8:5]; end // R8
          default: begin pa = {d2[31:10], va[9:0]}; sz = 3'd0; ap = {4{d2[5:4]}}; dom = d1[8:5]; end // R9
        endcase
      end
    endcase
  endtask

  task automatic setup(input logic [31:0] va, input logic [31:0] base,
                       input logic [31:0] d1, input logic [31:0] d2);
    logic [31:0] a0, a1;
    bmem.delete();
    a0 = {base[31:14], va[31:20], 2'b00};
    bmem[a0] = d1;
    if (d1[0]) begin
      a1 = (d1[1:0] == 2'b01) ? {d1[31:10], va[19:12], 2'b00}
                              : {d1[31:12], va[19:10], 2'b00};
      bmem[a1] = d2;
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input int hold);
    logic f, lvl;
    logic [31:0] pa, a0, a1;
    logic [2:0] sz;
    logic [3:0] dom;
    logic [7:0] ap;
    int nrd;
    string t;
    ref_walk(va, base, f, lvl, pa, sz, dom, ap, nrd, a0, a1);
    rd_cnt = 0;
    @(negedge clk);
    chk(req_ready && !busy, "R1 idle before request", {30'd0, req_ready, busy}, 32'h2);
    req_valid = 1'b1; req_va = va; req_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R1 busy after accept", {30'd0, req_ready, busy}, 32'h1);
    while (!resp_valid) @(negedge clk);
    t = f ? (lvl ? "R10" : "R3") :
        (sz == 3'd4 ? "R5" : sz == 3'd3 ? "R4" : sz == 3'd2 ? "R7" : sz == 3'd1 ? "R8" : "R9");
    chk(resp_fault == f && resp_lvl == lvl, {t, " fault/level"}, {30'd0, resp_fault, resp_lvl}, {30'd0, f, lvl});
    chk(resp_pa == pa, {t, " pa (R11 on fault)"}, resp_pa, pa);
    chk(resp_size == sz && resp_ap == ap, {t, " size/ap (R11 on fault)"},
        {21'd0, resp_size, resp_ap}, {21'd0, sz, ap});
    chk(resp_dom == dom, {t, " domain R10 R11"}, {28'd0, resp_dom}, {28'd0, dom});
    chk(rd_addr[0] == a0, "R2 first read address", rd_addr[0], a0);
    if (nrd == 2) chk(rd_addr[1] == a1, "R6 second read address", rd_addr[1], a1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(resp_valid && resp_pa == pa && busy, "R12 response held", resp_pa, pa);
    end
    chk(rd_cnt == nrd, {t, " read count R12"}, rd_cnt, nrd);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(!busy && !resp_valid && req_ready, "R1 idle after handshake",
        {29'd0, busy, resp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !resp_valid && !mem_req && req_ready, "R1 reset state",
        {28'd0, busy, resp_valid, mem_req, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    setup(32'h1234_5678, 32'h8000_4000, 32'h0000_0000, 0);
    walk(32'h1234_5678, 32'h8000_4000, 0);                         // R3
    setup(32'hABCD_EF01, 32'h0000_C000, 32'h5A50_0D62, 0);
    walk(32'hABCD_EF01, 32'h0000_C000, 2);                         // R4
    setup(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hC3FF_F9E2, 0);
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);                         // R5
    setup(32'h0000_0000, 32'h0000_0000, 32'h1234_5421, 32'hAAAA_5A55);
    walk(32'h0000_0000, 32'h0000_0000, 0);                         // R6 R7
    setup(32'h7654_3210, 32'h0001_0000, 32'h8765_41E1, 32'h1357_9CDE);
    walk(32'h7654_3210, 32'h0001_0000, 3);                         // R8
    setup(32'h3C3C_3FFF, 32'h4000_8000, 32'h0F0F_1F03, 32'hFFFF_FC33);
    walk(32'h3C3C_3FFF, 32'h4000_8000, 0);                         // R6 R9
    setup(32'h0010_0400, 32'h2222_0000, 32'h9999_9B03, 32'hFFFF_FFFC);
    walk(32'h0010_0400, 32'h2222_0000, 1);                         // R10
    // random walks
    for (int n = 0; n < 300; n++) begin
      logic [31:0] va, base, d1, d2;
      va = $urandom; base = $urandom; d1 = $urandom; d2 = $urandom;
      setup(va, base, d1, d2);
      walk(va, base, int'($urandom_range(2)));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule